// File: doc/BRIEF.md
# No-turnaround synchronous burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM meant to live inside a larger testbench or prototype. Each rising edge can carry one transfer, read or write, in any order. The bus never needs an idle cycle when traffic changes direction. Address, control and byte enables are registered on the rising edge. Write data follows its address later, and the delay depends on the selected output timing.

A static mode input selects one of two output timings. Flow-through timing drives read data in the cycle after the address edge and takes write data one edge after the address. Pipelined timing adds an output register, so read data appears one cycle later, and write data is taken two edges after its address. In pipelined timing a read can sample the array on the same edge at which an earlier write to the same word completes. The model forwards the arriving write data into that read.

A burst of up to four beats continues from a started access when the advance input is high. The beat order within the aligned group of four words is either linear or exclusive-or based. Three chip selects, per-lane write enables, an asynchronous output gate and a sleep input complete the interface.

Top module: `nbt_sram`

## Requirements
- R1: During and after reset, with no read accepted, `rdata_oe` is low and `rdata` is all zeros.
- R2: With `flow_mode`=1, a read accepted at edge k drives `rdata_oe`=1 and the addressed word on `rdata` during the cycle that follows edge k.
- R3: With `flow_mode`=0, a read accepted at edge k drives its word during the cycle that follows edge k+1, and during no other cycle.
- R4: A write accepted at edge k takes `wdata` at edge k+1 when `flow_mode`=1 and at edge k+2 when `flow_mode`=0. Values on `wdata` at any other edge do not reach the array.
- R5: Reads and writes may alternate on every edge with no idle cycles. Every read returns the word as left by all writes accepted before it, and this holds in pipelined mode even when the write's data arrives on the read's own array-sampling edge.
- R6: A word is LANES lanes of BYTE_W bits, with lane i at bits [BYTE_W*i+BYTE_W-1 : BYTE_W*i]. Only lanes whose `lane_we` bit was high at the address edge are changed.
- R7: A new access is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 and `adv`=0. Any other select pattern with `adv`=0 is a deselect: nothing is read or written, no data is driven, and any burst ends.
- R8: With `adv`=1 after a started access and `burst_xor`=0, the next beat repeats the started operation at the start address with its low two bits replaced by (start low bits + beat count) mod 4. `wr`, `addr` and the selects are ignored on that edge.
- R9: With `burst_xor`=1, the beat's low two bits are the start low bits XOR the beat count, and the count wraps to zero after the fourth beat.
- R10: `adv`=1 when no burst is open, after reset, a deselect or sleep, is ignored.
- R11: `oe_n`=1 forces `rdata_oe` low and `rdata` to zero in the same cycle. This does not disturb reads in flight, and later reads return correct data.
- R12: While `sleep`=1 no access or burst beat is accepted, the open burst ends, and the read outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = pipelined timing (static) |
| burst_xor | input | 1 | 1 = XOR beat order, 0 = linear (static) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | Continue the open burst with its next beat |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Word address |
| lane_we | input | LANES | Per-lane write enables, sampled with the address |
| wdata | input | LANES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output gate, active low |
| sleep | input | 1 | Power-down: blocks accesses and outputs |
| rdata | output | LANES*BYTE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data is being driven |

## Verification
The case that matters most is in pipelined timing: the late write of one access completes on the same edge at which a following read samples the array for the same word. The bench provokes this by issuing a write and, on the very next edge, a read of that word, once with all lanes enabled and once with a partial lane mask. A scoreboard models the memory in issue order and predicts the merged word, so any read that returns stale lanes is reported. A second overlap is tested as well: the output gate or sleep is raised in exactly the cycle a pending read would drive, and the bench expects silence there and correct data from the next read.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } beat_order_e;

   // low two address bits of a burst beat
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] count,
                                           input beat_order_e ord);
      return (ord == ORD_XOR) ? (start ^ count) : (start + count);
   endfunction

endpackage

// File: rtl/nbt_cmd_dec.sv
module nbt_cmd_dec
   import nbt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              sel_ok,
   input  logic              adv,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  be,
   input  beat_order_e       ord,
   output logic              cmd_v,
   output logic              cmd_wr,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [LANES-1:0]  cmd_be,
   output logic              burst_open
);

   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_START,
      ACT_STEP
   } act_e;

   act_e              act;
   logic              live_q;
   logic              wr_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [1:0]        cnt_nx;

   always_comb begin
      cnt_nx = cnt_q + 2'd1;
      if (sleep)       act = ACT_NONE;
      else if (adv)    act = live_q ? ACT_STEP : ACT_NONE;
      else if (sel_ok) act = ACT_START;
      else             act = ACT_NONE;
   end

   always_comb begin
      cmd_v  = (act != ACT_NONE);
      cmd_be = be;
      if (act == ACT_STEP) begin
         cmd_wr   = wr_q;
         cmd_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nx, ord)};
      end else begin
         cmd_wr   = wr;
         cmd_addr = addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         wr_q   <= 1'b0;
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else begin
         case (act)
            ACT_START: begin
               live_q <= 1'b1;
               wr_q   <= wr;
               base_q <= addr;
               cnt_q  <= 2'd0;
            end
            ACT_STEP: cnt_q <= cnt_nx;
            default:  live_q <= 1'b0;
         endcase
      end
   end

   assign burst_open = live_q;

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wbe,
   input  logic [LANES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[ln]) cells[waddr] <= wdata[ln*BYTE_W +: BYTE_W];
      end

      assign rdata[ln*BYTE_W +: BYTE_W] = cells[raddr];
   end

endmodule

// File: rtl/nbt_rd_out.sv
module nbt_rd_out #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flow,
   input  logic                    rd_v,
   input  logic [LANES*BYTE_W-1:0] arr_q,
   input  logic                    fwd_hit,
   input  logic [LANES-1:0]        fwd_be,
   input  logic [LANES*BYTE_W-1:0] fwd_data,
   output logic                    drive,
   output logic [LANES*BYTE_W-1:0] data
);

   localparam int DATA_W = LANES * BYTE_W;

   logic [DATA_W-1:0] merged;
   logic              out_v;
   logic [DATA_W-1:0] out_d;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_merge
      assign merged[ln*BYTE_W +: BYTE_W] = (fwd_hit && fwd_be[ln]) ?
                                           fwd_data[ln*BYTE_W +: BYTE_W] :
                                           arr_q[ln*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         out_d <= '0;
      end else begin
         out_v <= rd_v && !flow;
         out_d <= merged;
      end
   end

   assign drive = flow ? rd_v  : out_v;
   assign data  = flow ? arr_q : out_d;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
   import nbt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flow_mode,
   input  logic                    burst_xor,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    adv,
   input  logic                    wr,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*BYTE_W-1:0] wdata,
   input  logic                    oe_n,
   input  logic                    sleep,
   output logic [LANES*BYTE_W-1:0] rdata,
   output logic                    rdata_oe
);

   localparam int DATA_W = LANES * BYTE_W;

   if (ADDR_W < 3)  begin : g_bad_aw   $error("nbt_sram: ADDR_W must be at least 3"); end
   if (LANES < 1)   begin : g_bad_ln   $error("nbt_sram: LANES must be at least 1"); end
   if (BYTE_W < 1)  begin : g_bad_bw   $error("nbt_sram: BYTE_W must be at least 1"); end

   logic              sel_ok;
   logic              cmd_v, cmd_wr, burst_open;
   logic [ADDR_W-1:0] cmd_addr;
   logic [LANES-1:0]  cmd_be;

   logic              s1_v, s1_wr, s2_v, s2_wr;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s1_be, s2_be;

   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [LANES-1:0]  mem_wbe;
   logic [DATA_W-1:0] arr_q;
   logic              fwd_hit;
   logic              rd_drive;
   logic [DATA_W-1:0] rd_data;

   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   nbt_cmd_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep      (sleep),
      .sel_ok     (sel_ok),
      .adv        (adv),
      .wr         (wr),
      .addr       (addr),
      .be         (lane_we),
      .ord        (beat_order_e'(burst_xor)),
      .cmd_v      (cmd_v),
      .cmd_wr     (cmd_wr),
      .cmd_addr   (cmd_addr),
      .cmd_be     (cmd_be),
      .burst_open (burst_open)
   );

   // two in-flight stages: address edge, then one edge later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_wr   <= 1'b0;
         s1_addr <= '0;
         s1_be   <= '0;
         s2_v    <= 1'b0;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_be   <= '0;
      end else begin
         s1_v    <= cmd_v;
         s1_wr   <= cmd_wr;
         s1_addr <= cmd_addr;
         s1_be   <= cmd_be;
         s2_v    <= s1_v;
         s2_wr   <= s1_wr;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   // single late write commits from stage 1, double late write from stage 2
   always_comb begin
      if (flow_mode) begin
         mem_we    = s1_v && s1_wr;
         mem_waddr = s1_addr;
         mem_wbe   = s1_be;
      end else begin
         mem_we    = s2_v && s2_wr;
         mem_waddr = s2_addr;
         mem_wbe   = s2_be;
      end
   end

   nbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wbe   (mem_wbe),
      .wdata (wdata),
      .raddr (s1_addr),
      .rdata (arr_q)
   );

   assign fwd_hit = !flow_mode && s2_v && s2_wr && (s2_addr == s1_addr);

   nbt_rd_out #(.LANES(LANES), .BYTE_W(BYTE_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .flow     (flow_mode),
      .rd_v     (s1_v && !s1_wr),
      .arr_q    (arr_q),
      .fwd_hit  (fwd_hit),
      .fwd_be   (s2_be),
      .fwd_data (wdata),
      .drive    (rd_drive),
      .data     (rd_data)
   );

   assign rdata_oe = rd_drive && !oe_n && !sleep;
   assign rdata    = rdata_oe ? rd_data : '0;

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic flow_mode,
   input logic sleep,
   input logic sel_a_n,
   input logic sel_b,
   input logic sel_c_n,
   input logic adv,
   input logic cmd_v,
   input logic cmd_wr,
   input logic rd_drive,
   input logic mem_we
);

   a_r2_flow_read_next: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_v && !cmd_wr && flow_mode) |=> (rd_drive || !flow_mode));

   a_r3_pipe_read_second: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_v && !cmd_wr && !flow_mode) |-> ##2 (rd_drive || flow_mode));

   a_r4_flow_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && $past(flow_mode) && $past(rst_n) && $past(cmd_v && cmd_wr)) |-> mem_we);

   a_r4_pipe_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && $past(!flow_mode) && $past(!flow_mode, 2) && $past(rst_n, 2)
       && $past(cmd_v && cmd_wr, 2)) |-> mem_we);

   a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && (sel_a_n || !sel_b || sel_c_n)) |-> !cmd_v);

   a_r12_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !cmd_v);

endmodule

bind nbt_sram nbt_sram_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flow_mode (flow_mode),
   .sleep     (sleep),
   .sel_a_n   (sel_a_n),
   .sel_b     (sel_b),
   .sel_c_n   (sel_c_n),
   .adv       (adv),
   .cmd_v     (cmd_v),
   .cmd_wr    (cmd_wr),
   .rd_drive  (rd_drive),
   .mem_we    (mem_we)
);

// File: tb/tb_nbt_sram.sv
`timescale 1ns/1ps
module tb_nbt_sram;

   localparam int AW = 8;
   localparam int LN = 4;
   localparam int BW = 9;
   localparam int DW = LN * BW;
   localparam logic [2:0] SEL_ON  = 3'b010;   // {sel_a_n, sel_b, sel_c_n}
   localparam logic [2:0] SEL_OFF = 3'b101;
   localparam logic [DW-1:0] JUNK = 36'h5A5A_5A5A5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flow_mode = 1'b1, burst_xor = 1'b0;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          adv = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [LN-1:0] lane_we = '0;
   logic [DW-1:0] wdata = '0;
   logic          oe_n = 1'b0, sleep = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   nbt_sram #(.ADDR_W(AW), .LANES(LN), .BYTE_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_xor(burst_xor),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv), .wr(wr),
      .addr(addr), .lane_we(lane_we), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int            due;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;
   exp_t q[$];

   logic [DW-1:0] ref_mem [256];
   logic [DW-1:0] wd_slot [4];
   bit            wd_has  [4];
   bit            b_live = 1'b0;
   bit            b_wr = 1'b0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   bit            tb_oe_n = 1'b0;
   bit            tb_sleep = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   // driver: one transfer slot per call; model updated in issue order
   task automatic step(input logic [2:0] sels, input bit s_adv, input bit s_wr,
                       input logic [AW-1:0] a, input logic [LN-1:0] be,
                       input logic [DW-1:0] d, input string tag);
      int c, lat;
      bit acc, ew;
      logic [AW-1:0] ea;
      @(negedge clk);
      c = cyc;
      {sel_a_n, sel_b, sel_c_n} = sels;
      adv = s_adv; wr = s_wr; addr = a; lane_we = be;
      oe_n = tb_oe_n; sleep = tb_sleep;
      wdata = wd_has[c % 4] ? wd_slot[c % 4] : (JUNK ^ DW'(c));
      wd_has[c % 4] = 1'b0;
      acc = 1'b0; ew = 1'b0; ea = a;
      if (tb_sleep) begin
         b_live = 1'b0;
      end else if (s_adv) begin
         if (b_live) begin
            b_cnt = b_cnt + 2'd1;
            ea = {b_base[AW-1:2], burst_xor ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            ew = b_wr; acc = 1'b1;
         end
      end else if (sels == SEL_ON) begin
         acc = 1'b1; ew = s_wr;
         b_live = 1'b1; b_base = a; b_cnt = 2'd0; b_wr = s_wr;
      end else begin
         b_live = 1'b0;
      end
      lat = flow_mode ? 1 : 2;
      if (acc) begin
         if (ew) begin
            for (int l = 0; l < LN; l++)
               if (be[l]) ref_mem[ea][l*BW +: BW] = d[l*BW +: BW];
            wd_slot[(c + lat) % 4] = d;
            wd_has[(c + lat) % 4] = 1'b1;
         end else begin
            q.push_back('{c + lat, ref_mem[ea], tag});
         end
      end
   endtask

   task automatic wr_op(input logic [AW-1:0] a, input logic [LN-1:0] be,
                        input logic [DW-1:0] d, input string tag);
      step(SEL_ON, 1'b0, 1'b1, a, be, d, tag);
   endtask

   task automatic rd_op(input logic [AW-1:0] a, input string tag);
      step(SEL_ON, 1'b0, 1'b0, a, '0, '0, tag);
   endtask

   task automatic adv_op(input logic [DW-1:0] d, input string tag);
      step(SEL_OFF, 1'b1, 1'b0, 8'hFF, {LN{1'b1}}, d, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(SEL_OFF, 1'b0, 1'b0, '0, '0, '0, "idle");
   endtask

   // monitor: pops the scoreboard when an item falls due
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            if (oe_n || sleep)
               chk(rdata_oe === 1'b0 && rdata === '0, {e.tag, " R11/R12 gated"}, rdata, '0);
            else
               chk(rdata_oe === 1'b1 && rdata === e.data, e.tag, rdata, e.data);
         end else if (rdata_oe !== 1'b0) begin
            chk(1'b0, "R7 drive without accepted read", rdata, '0);
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      #1;
      chk(rdata_oe === 1'b0 && rdata === '0, "R1 in reset", rdata, '0);
      rst_n = 1'b1;
      idle(2);
      #1;
      chk(rdata_oe === 1'b0 && rdata === '0, "R1 after reset", rdata, '0);

      // ---------- flow-through timing ----------
      flow_mode = 1'b1; burst_xor = 1'b0;
      wr_op(8'h10, 4'hF, 36'h1_1111_1111, "R4");
      rd_op(8'h10, "R2 R5 flow read after write");
      wr_op(8'h11, 4'hF, 36'h2_2222_2222, "R4");
      rd_op(8'h11, "R5 flow");
      rd_op(8'h10, "R2 flow");
      wr_op(8'h10, 4'hF, 36'h3_3333_3333, "R4");
      rd_op(8'h10, "R5 flow overwrite");
      wr_op(8'h12, 4'hF, 36'h4_4444_4444, "R6");
      wr_op(8'h12, 4'b0101, 36'h5_5555_5555, "R6");
      rd_op(8'h12, "R6 flow lane mask");
      wr_op(8'h13, 4'hF, 36'h6_6666_6666, "R4");
      idle(2);
      rd_op(8'h13, "R4 flow junk ignored");
      wr_op(8'h14, 4'hF, 36'h7_7777_7777, "R7");
      step(3'b011, 1'b0, 1'b1, 8'h14, 4'hF, 36'h8_8888_8888, "R7");
      step(3'b000, 1'b0, 1'b1, 8'h14, 4'hF, 36'h8_8888_8888, "R7");
      step(3'b110, 1'b0, 1'b0, 8'h14, 4'hF, 36'h8_8888_8888, "R7");
      rd_op(8'h14, "R7 partial select ignored");
      idle(1);
      adv_op(36'h9_9999_9999, "R10");
      rd_op(8'h14, "R10 stray advance ignored");
      // R11: gate the cycle the read would drive
      rd_op(8'h10, "R11 flow");
      tb_oe_n = 1'b1; idle(1); tb_oe_n = 1'b0;
      rd_op(8'h10, "R11 flow after gate");
      // R12: sleep blocks accesses
      tb_sleep = 1'b1;
      wr_op(8'h14, 4'hF, 36'hA_AAAA_AAAA, "R12");
      rd_op(8'h14, "R12");
      tb_sleep = 1'b0;
      rd_op(8'h14, "R12 after sleep");
      // R8: linear write burst from low bits 2, then read burst from 1
      wr_op(8'h22, 4'hF, 36'h0_0000_00A0, "R8");
      adv_op(36'h0_0000_00A1, "R8");
      adv_op(36'h0_0000_00A2, "R8");
      adv_op(36'h0_0000_00A3, "R8");
      rd_op(8'h20, "R8 beat 3");
      rd_op(8'h21, "R8 beat 4");
      rd_op(8'h22, "R8 beat 1");
      rd_op(8'h23, "R8 beat 2");
      rd_op(8'h21, "R8 read burst");
      adv_op('0, "R8 read burst");
      adv_op('0, "R8 read burst");
      adv_op('0, "R8 read burst wrap");
      idle(4);

      // ---------- pipelined timing ----------
      flow_mode = 1'b0; burst_xor = 1'b1;
      idle(2);
      wr_op(8'h30, 4'hF, 36'hB_0000_0030, "R4");
      rd_op(8'h30, "R5 pipe forward");
      wr_op(8'h31, 4'hF, 36'hB_0000_0031, "R4");
      rd_op(8'h30, "R3 pipe");
      rd_op(8'h31, "R5 pipe");
      wr_op(8'h30, 4'hF, 36'hC_0000_0030, "R4");
      rd_op(8'h30, "R5 pipe forward overwrite");
      wr_op(8'h31, 4'b1010, 36'hD_DDDD_DDDD, "R6");
      rd_op(8'h31, "R6 pipe forward lane merge");
      idle(3);
      rd_op(8'h31, "R6 pipe settled");
      // R9: XOR burst from low bits 1
      wr_op(8'h45, 4'hF, 36'h0_0000_0E45, "R9");
      adv_op(36'h0_0000_0E44, "R9");
      adv_op(36'h0_0000_0E47, "R9");
      adv_op(36'h0_0000_0E46, "R9");
      rd_op(8'h44, "R9 beat 2");
      rd_op(8'h45, "R9 beat 1");
      rd_op(8'h46, "R9 beat 4");
      rd_op(8'h47, "R9 beat 3");
      rd_op(8'h46, "R9 read burst");
      adv_op('0, "R9 read burst");
      adv_op('0, "R9 read burst");
      adv_op('0, "R9 read burst");
      adv_op('0, "R9 wrap to start");
      idle(1);
      rd_op(8'h30, "R11 pipe");
      idle(1);
      tb_oe_n = 1'b1; idle(1); tb_oe_n = 1'b0;
      rd_op(8'h30, "R11 pipe after gate");
      rd_op(8'h31, "R12 pipe");
      idle(1);
      tb_sleep = 1'b1; idle(1); tb_sleep = 1'b0;
      rd_op(8'h31, "R12 pipe after sleep");
      idle(6);
      #1;
      chk(q.size() == 0, "R3 all reads delivered", DW'(q.size()), '0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule